// File: doc/BRIEF.md
# Row Tile Repeat Buffer

This block keeps the tile codes of one row of background tiles for a scanned display. A fetch engine delivers a group of codes, one per tile position across the row, each marked by a valid strobe. The block takes the group once, then replays it to the pixel side on every scan line of that tile row. Each tile is 8 lines tall and the line count is doubled for interlace, so one group serves 16 lines before the next group is needed.

The pixel side asks for codes one at a time. Every request rotates the buffer by one position, so the whole row comes out in order and then starts again at entry 0. A line-start pulse advances a line counter. When the counter wraps, the block raises a load request and takes the next group. After the last row of the screen it raises a frame-done level instead, which an interrupt request can use. A frame-start pulse sends the block back to the first line of the first row and asks for a fresh group.

Top module: `tile_row_buffer`

## Requirements
- R1: After reset, loadReq is 1, frameDone is 0, outIdx is 0 and outCode is 0.
- R2: While loadReq is 1, each clock with inValid high accepts inCode as the next entry. loadReq falls in the cycle after the NUM_TILES-th accepted code, and then outIdx is 0 and outCode is the first accepted code.
- R3: While loadReq is 0, each clock with outReq high advances to the next entry. outIdx rises by one and outCode becomes the code that was accepted in that position.
- R4: A request at outIdx NUM_TILES-1 returns to outIdx 0 and the first code of the group.
- R5: outReq has no effect while loadReq is 1 (outIdx stays 0). inValid has no effect while loadReq is 0 (outCode and outIdx do not change).
- R6: In each row, the first LINES_PER_ROW-1 lineStart pulses leave loadReq at 0 and keep the same codes in replay. The LINES_PER_ROW-th pulse sets loadReq to 1, unless that row is the last one.
- R7: The line wrap that ends row ROWS_PER_FRAME-1 (rows are counted from 0) sets frameDone to 1 and leaves loadReq at 0. While frameDone is 1, lineStart pulses have no effect.
- R8: A frameStart pulse sets loadReq to 1, clears frameDone, sets outIdx to 0, and restarts the line and row counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| frameStart | input | 1 | One-cycle pulse at the start of a screen |
| lineStart | input | 1 | One-cycle pulse at the start of each scan line |
| inValid | input | 1 | inCode carries a code to be loaded |
| inCode | input | CODE_W | Tile code from the fetch engine |
| outReq | input | 1 | Advance to the next entry |
| outCode | output | CODE_W | Tile code of the current entry |
| outIdx | output | IDX_W | Position of the current entry in the row |
| loadReq | output | 1 | The buffer is waiting for a new group |
| frameDone | output | 1 | All rows of the screen have been served |

## Verification
The bench keeps NUM_TILES at 20 and LINES_PER_ROW at 16, so the full row length and the interlaced line period are both tested as the default build uses them. It sets ROWS_PER_FRAME to 3, which brings the end of the screen, the frame-done freeze and the restart after frameStart within a few thousand cycles. Random gaps between codes, random request counts per line and stray strobes test the index wrap and the rejected inputs from many starting positions.

// File: rtl/tile_buf_pkg.sv
package tile_buf_pkg;
  // Strobes from the sequencer to the code store
  typedef struct packed {
    logic shiftIn;  // accept a new code at the tail
    logic rotate;   // move the head entry to the tail
  } bufStrobes_t;
endpackage

// File: rtl/tile_buf_store.sv
module tile_buf_store
  import tile_buf_pkg::*;
#(
  parameter int NUM_TILES = 20,
  parameter int CODE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobes_t       str,
  input  logic [CODE_W-1:0] inCode,
  output logic [CODE_W-1:0] outCode
);
  logic [CODE_W-1:0] slot [NUM_TILES];

  for (genvar i = 0; i < NUM_TILES; i++) begin : g_slot
    logic [CODE_W-1:0] nextVal;
    if (i == NUM_TILES - 1) begin : g_tail
      assign nextVal = str.shiftIn ? inCode : slot[0];
    end else begin : g_body
      assign nextVal = slot[i+1];
    end
    always_ff @(posedge clk) begin
      if (!rstN) slot[i] <= '0;
      else if (str.shiftIn || str.rotate) slot[i] <= nextVal;
    end
  end

  assign outCode = slot[0];

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(str.shiftIn && str.rotate));

  assert_rotate_tail_R3: assert property (@(posedge clk) disable iff (!rstN)
    str.rotate |=> slot[NUM_TILES-1] == $past(slot[0]));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !str.shiftIn && !str.rotate |=> $stable(outCode));
endmodule

// File: rtl/tile_buf_seq.sv
module tile_buf_seq
  import tile_buf_pkg::*;
#(
  parameter int NUM_TILES      = 20,
  parameter int LINES_PER_ROW  = 16,
  parameter int ROWS_PER_FRAME = 12,
  localparam int IDX_W  = $clog2(NUM_TILES + 1),
  localparam int LINE_W = $clog2(LINES_PER_ROW + 1),
  localparam int ROW_W  = $clog2(ROWS_PER_FRAME + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             lineStart,
  input  logic             inValid,
  input  logic             outReq,
  output bufStrobes_t      str,
  output logic [IDX_W-1:0] outIdx,
  output logic             loadReq,
  output logic             frameDone
);
  logic              loading;
  logic [IDX_W-1:0]  loadCnt;
  logic [LINE_W-1:0] lineCnt;
  logic [ROW_W-1:0]  rowCnt;
  logic lineLast, rowLast, loadLast, idxLast;

  assign lineLast = lineCnt == LINE_W'(LINES_PER_ROW - 1);
  assign rowLast  = rowCnt  == ROW_W'(ROWS_PER_FRAME - 1);
  assign loadLast = loadCnt == IDX_W'(NUM_TILES - 1);
  assign idxLast  = outIdx  == IDX_W'(NUM_TILES - 1);

  always_comb begin
    str.shiftIn = inValid && loading && !frameStart;
    str.rotate  = outReq && !loading && !frameStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN || frameStart) begin
      loading   <= 1'b1;
      loadCnt   <= '0;
      lineCnt   <= '0;
      rowCnt    <= '0;
      outIdx    <= '0;
      frameDone <= 1'b0;
    end else begin
      if (str.shiftIn) begin
        outIdx  <= '0;
        loadCnt <= loadLast ? '0 : loadCnt + 1'b1;
        if (loadLast) loading <= 1'b0;
      end
      if (str.rotate) outIdx <= idxLast ? '0 : outIdx + 1'b1;
      if (lineStart && !frameDone) begin
        if (lineLast) begin
          lineCnt <= '0;
          if (rowLast) begin
            frameDone <= 1'b1;
          end else begin
            rowCnt  <= rowCnt + 1'b1;
            loading <= 1'b1;
            loadCnt <= '0;
            outIdx  <= '0;
          end
        end else begin
          lineCnt <= lineCnt + 1'b1;
        end
      end
    end
  end

  assign loadReq = loading;

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    outIdx < IDX_W'(NUM_TILES));

  assert_load_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    str.shiftIn && loadLast && !lineStart |=> !loadReq && outIdx == '0);

  assert_frame_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> loadReq && !frameDone && lineCnt == '0 && rowCnt == '0);

  assert_done_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && !frameStart |=> frameDone && $stable(rowCnt) && $stable(lineCnt));

  assert_done_noload_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameDone) |-> !loadReq);
endmodule

// File: rtl/tile_row_buffer.sv
module tile_row_buffer
  import tile_buf_pkg::*;
#(
  parameter int NUM_TILES      = 20,
  parameter int CODE_W         = 8,
  parameter int LINES_PER_ROW  = 16,
  parameter int ROWS_PER_FRAME = 12,
  localparam int IDX_W = $clog2(NUM_TILES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic              inValid,
  input  logic [CODE_W-1:0] inCode,
  input  logic              outReq,
  output logic [CODE_W-1:0] outCode,
  output logic [IDX_W-1:0]  outIdx,
  output logic              loadReq,
  output logic              frameDone
);
  bufStrobes_t str;

  tile_buf_seq #(
    .NUM_TILES(NUM_TILES), .LINES_PER_ROW(LINES_PER_ROW), .ROWS_PER_FRAME(ROWS_PER_FRAME)
  ) u_seq (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .inValid(inValid), .outReq(outReq), .str(str), .outIdx(outIdx),
    .loadReq(loadReq), .frameDone(frameDone)
  );

  tile_buf_store #(.NUM_TILES(NUM_TILES), .CODE_W(CODE_W)) u_store (
    .clk(clk), .rstN(rstN), .str(str), .inCode(inCode), .outCode(outCode)
  );
endmodule

// File: tb/tile_row_buffer_tb.sv
module tile_row_buffer_tb;
  localparam int NT = 20, CW = 8, LPR = 16, RPF = 3;
  localparam int IW = $clog2(NT + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic frameStart = 0, lineStart = 0, inValid = 0, outReq = 0;
  logic [CW-1:0] inCode = '0;
  logic [CW-1:0] outCode;
  logic [IW-1:0] outIdx;
  logic loadReq, frameDone;

  int checks = 0, fails = 0;
  logic [CW-1:0] expCodes [NT];
  int expHead = 0;

  always #4 clk = ~clk;

  tile_row_buffer #(.NUM_TILES(NT), .CODE_W(CW), .LINES_PER_ROW(LPR), .ROWS_PER_FRAME(RPF)) u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .inValid(inValid), .inCode(inCode), .outReq(outReq), .outCode(outCode),
    .outIdx(outIdx), .loadReq(loadReq), .frameDone(frameDone)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nextHead(int h);
    return (h == NT - 1) ? 0 : h + 1;
  endfunction

  // one cycle: inputs set at negedge, results visible at the following negedge
  task automatic cyc();
    @(negedge clk);
    frameStart = 0; lineStart = 0; inValid = 0; outReq = 0;
  endtask

  task automatic loadRow(bit strayReq);
    for (int i = 0; i < NT; i++) begin
      while ($urandom_range(3) == 0) begin
        outReq = strayReq;
        cyc();
        chk("R5 req during load", outIdx, 0);
        chk("R2 still loading", loadReq, 1);
      end
      expCodes[i] = CW'($urandom);
      inCode = expCodes[i]; inValid = 1;
      cyc();
      chk("R2 loadReq level", loadReq, (i == NT - 1) ? 0 : 1);
    end
    expHead = 0;
    chk("R2 head idx", outIdx, 0);
    chk("R2 head code", outCode, expCodes[0]);
  endtask

  task automatic replay(int n);
    for (int k = 0; k < n; k++) begin
      if ($urandom_range(7) == 0) begin
        inValid = 1; inCode = CW'($urandom);
        cyc();
        chk("R5 valid in replay code", outCode, expCodes[expHead]);
        chk("R5 valid in replay idx", outIdx, expHead);
      end
      outReq = 1;
      cyc();
      expHead = nextHead(expHead);
      chk(expHead == 0 ? "R4 wrap idx" : "R3 idx", outIdx, expHead);
      chk(expHead == 0 ? "R4 wrap code" : "R3 code", outCode, expCodes[expHead]);
    end
  endtask

  task automatic runRow(bit lastRow);
    for (int ln = 0; ln < LPR; ln++) begin
      replay($urandom_range(NT + 6));
      lineStart = 1;
      cyc();
      if (ln < LPR - 1) begin
        chk("R6 no load mid row", loadReq, 0);
        chk("R6 same codes", outCode, expCodes[expHead]);
      end else if (lastRow) begin
        chk("R7 frameDone", frameDone, 1);
        chk("R7 no loadReq", loadReq, 0);
      end else begin
        chk("R6 loadReq at wrap", loadReq, 1);
        chk("R6 not done", frameDone, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 loadReq", loadReq, 1);
    chk("R1 frameDone", frameDone, 0);
    chk("R1 outIdx", outIdx, 0);
    chk("R1 outCode", outCode, 0);
    rstN = 1;
    cyc();

    for (int r = 0; r < RPF; r++) begin
      loadRow(r == 0);
      runRow(r == RPF - 1);
    end

    // R7: lines after the end of the screen are ignored
    repeat (LPR + 2) begin lineStart = 1; cyc(); end
    chk("R7 frozen done", frameDone, 1);
    chk("R7 frozen loadReq", loadReq, 0);
    replay(NT + 3);

    // R8: restart mid replay
    frameStart = 1;
    cyc();
    chk("R8 loadReq", loadReq, 1);
    chk("R8 frameDone", frameDone, 0);
    chk("R8 outIdx", outIdx, 0);
    loadRow(1);
    runRow(0);

    // R8: restart in the middle of a load
    inValid = 1; inCode = 8'h5a; cyc();
    inValid = 1; inCode = 8'h3c; cyc();
    frameStart = 1; cyc();
    chk("R8 restart load", loadReq, 1);
    loadRow(0);
    replay(NT);
    runRow(0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule